// File: doc/BRIEF.md
# Speculative Shadow Release Tracker

This block follows, in program order, every instruction that can still force younger work to be thrown away: branches whose outcome is not yet confirmed, operations that might fault, and stores whose address is unknown. Each such caster takes a slot in a circular ring when it is dispatched. The slot number comes back on `cast_idx` and is kept with the instruction, so that it can later mark its own slot resolved. Slots leave the ring only from the oldest end, one per cycle, and only once they are resolved.

Each dispatched load is classified at once. If no caster older than the load is still in the ring, the load is unshadowed and may run normally. Otherwise the load is reported as shadowed. Its load-queue index is then queued together with a stamp, which is the ring slot of the youngest caster older than the load. When that stamped slot is the oldest ring entry and is resolved, the load is released on one of the `rel_*` lanes, and the load queue can then treat it as non-speculative. The release is found by comparing the stamp at the queue front with the ring's oldest slot, with no search across entries. A squash rewinds the ring's young end to a given slot and discards the queued loads that depended on the discarded casters.

Top module: `shadow_release_tracker`

## Requirements
- R1: After reset the ring and the release queue are empty: no lane of `rel_valid` is set, `cast_idx` is 0, and a load dispatched without a caster is unshadowed.
- R2: A caster dispatched while no squash is present receives on `cast_idx`, in the same cycle, the slot after the one given to the previous caster, wrapping modulo SB_DEPTH.
- R3: Casters may be resolved in any order, but the ring frees only its oldest slot, at most one slot per cycle, and only after that slot is resolved. A load is never released while a caster older than it or equal to its stamp is unresolved.
- R4: A load dispatched in a cycle where the ring is empty, once counting the slot freed in that same cycle, and no caster is dispatched alongside it, has `ld_shadowed` = 0 and is never released.
- R5: A shadowed load is released exactly once, in the cycle when its stamp slot is the oldest ring entry and is resolved, with its load-queue index on the lane it occupies.
- R6: Releases come out in load dispatch order. In a cycle, lane k (bit k of `rel_valid`, index at bits [k*LQ_IW +: LQ_IW] of `rel_lq_idx`) is used only if every lane below k is used.
- R7: At most REL_W loads are released per cycle. If more loads carry the oldest slot's stamp, that slot stays in the ring and the remaining loads are released in the following cycles.
- R8: A squash with slot s, which is a live slot, rewinds the ring so that the next caster receives slot s. It discards every queued load whose stamp is s or younger, and keeps the older loads in order.
- R9: A load dispatched in the same cycle as a caster is younger than that caster: it is shadowed, and its stamp is the caster's slot.
- R10: A resolve takes effect from the next cycle. A release made possible by a resolve appears no earlier than the cycle after the resolve is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cast_valid | input | 1 | A shadow caster is dispatched this cycle |
| cast_idx | output | SB_IW | Ring slot given to the caster dispatched this cycle |
| res_valid | input | 1 | A caster stops casting its shadow |
| res_idx | input | SB_IW | Ring slot of the caster being resolved |
| ld_valid | input | 1 | A load is dispatched this cycle |
| ld_lq_idx | input | LQ_IW | Load-queue index of the dispatched load |
| ld_shadowed | output | 1 | The dispatched load must be treated as speculative |
| sq_valid | input | 1 | Squash request |
| sq_idx | input | SB_IW | Oldest ring slot to discard on squash |
| rel_valid | output | REL_W | Per-lane release strobe, lane 0 first |
| rel_lq_idx | output | REL_W*LQ_IW | Load-queue indices of released loads, lane k at bits [k*LQ_IW +: LQ_IW] |

## Verification
The assertions take for granted that no caster is dispatched into a full ring, that fewer loads are pending than the load queue holds, and that a resolve or squash names a slot currently in the ring. They also assume that no caster or load is dispatched in a squash cycle. The stimulus keeps to these limits by tracking occupancy and the live slot range in the bench model. Resolve targets are drawn only from live unresolved slots, squash points only from live slots, and dispatch is held off while a squash is presented or a structure is full. Directed sequences force several loads onto one stamp, out-of-order resolution and a squash in the middle of the ring.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int unsigned SRT_SB_DEPTH_DEF = 16;
  localparam int unsigned SRT_LQ_DEPTH_DEF = 8;
  localparam int unsigned SRT_REL_W_DEF    = 2;

  function automatic int unsigned srt_min(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/srt_caster_ring.sv
module srt_caster_ring #(
  parameter int unsigned DEPTH = srt_pkg::SRT_SB_DEPTH_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cast_valid,
  input  logic                       res_valid,
  input  logic [$clog2(DEPTH)-1:0]   res_idx,
  input  logic                       sq_valid,
  input  logic [$clog2(DEPTH)-1:0]   sq_idx,
  input  logic                       retire_ok,
  output logic [$clog2(DEPTH):0]     head_ptr,
  output logic [$clog2(DEPTH):0]     tail_ptr,
  output logic [$clog2(DEPTH):0]     head_nxt,
  output logic                       head_resolved,
  output logic [$clog2(DEPTH)-1:0]   sq_dist
);
  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned PW = IW + 1;

  logic [PW-1:0]    head_q, head_d, tail_q, tail_d;
  logic [DEPTH-1:0] resolved_q, resolved_d;
  logic             resolved_we, retire, empty;

  always_comb begin
    empty         = (head_q == tail_q);
    head_resolved = !empty && resolved_q[head_q[IW-1:0]];
    retire        = head_resolved && retire_ok && !sq_valid;
    sq_dist       = sq_idx - head_q[IW-1:0];
    head_d        = retire ? head_q + PW'(1) : head_q;
    if (sq_valid)        tail_d = head_q + {1'b0, sq_dist};
    else if (cast_valid) tail_d = tail_q + PW'(1);
    else                 tail_d = tail_q;
    resolved_we = (cast_valid && !sq_valid) || res_valid;
    resolved_d  = resolved_q;
    if (cast_valid && !sq_valid) resolved_d[tail_q[IW-1:0]] = 1'b0;
    if (res_valid)               resolved_d[res_idx]        = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      resolved_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      if (resolved_we) resolved_q <= resolved_d;
    end
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;
  assign head_nxt = head_d;
endmodule

// File: rtl/srt_release_fifo.sv
module srt_release_fifo #(
  parameter int unsigned DEPTH    = srt_pkg::SRT_LQ_DEPTH_DEF,
  parameter int unsigned SB_DEPTH = srt_pkg::SRT_SB_DEPTH_DEF,
  parameter int unsigned REL_W    = srt_pkg::SRT_REL_W_DEF
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [$clog2(DEPTH)-1:0]         push_lq,
  input  logic [$clog2(SB_DEPTH)-1:0]      push_stamp,
  input  logic [$clog2(SB_DEPTH)-1:0]      sb_head,
  input  logic                             head_resolved,
  input  logic                             sq_valid,
  input  logic [$clog2(SB_DEPTH)-1:0]      sq_dist,
  output logic [REL_W-1:0]                 rel_valid,
  output logic [REL_W*$clog2(DEPTH)-1:0]   rel_lq,
  output logic                             hold
);
  localparam int unsigned LW  = $clog2(DEPTH);
  localparam int unsigned LPW = LW + 1;
  localparam int unsigned IW  = $clog2(SB_DEPTH);

  logic [LW-1:0]  lq_q [DEPTH];
  logic [IW-1:0]  st_q [DEPTH];
  logic [LPW-1:0] head_q, head_d, tail_q, tail_d, count, npop, kept;
  logic           run;
  logic [LW-1:0]  slot;
  logic [IW-1:0]  age;

  always_comb begin
    count  = tail_q - head_q;
    run    = head_resolved && !sq_valid;
    npop   = '0;
    rel_lq = '0;
    for (int k = 0; k < REL_W; k++) begin
      slot = head_q[LW-1:0] + LW'(k);
      run  = run && (LPW'(k) < count) && (st_q[slot] == sb_head);
      rel_valid[k]        = run;
      rel_lq[k*LW +: LW]  = lq_q[slot];
      npop = npop + LPW'(run);
    end
    slot = head_q[LW-1:0] + LW'(REL_W);
    hold = run && (LPW'(REL_W) < count) && (st_q[slot] == sb_head);

    kept = '0;
    for (int j = 0; j < DEPTH; j++) begin
      slot = head_q[LW-1:0] + LW'(j);
      age  = st_q[slot] - sb_head;
      if ((LPW'(j) < count) && (age < sq_dist)) kept = kept + LPW'(1);
    end

    head_d = head_q + npop;
    if (sq_valid)  tail_d = head_q + kept;
    else if (push) tail_d = tail_q + LPW'(1);
    else           tail_d = tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !sq_valid) begin
      lq_q[tail_q[LW-1:0]] <= push_lq;
      st_q[tail_q[LW-1:0]] <= push_stamp;
    end
  end
endmodule

// File: rtl/shadow_release_tracker.sv
module shadow_release_tracker #(
  parameter int unsigned SB_DEPTH = srt_pkg::SRT_SB_DEPTH_DEF,
  parameter int unsigned LQ_DEPTH = srt_pkg::SRT_LQ_DEPTH_DEF,
  parameter int unsigned REL_W    = srt_pkg::SRT_REL_W_DEF
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cast_valid,
  output logic [$clog2(SB_DEPTH)-1:0]         cast_idx,
  input  logic                                res_valid,
  input  logic [$clog2(SB_DEPTH)-1:0]         res_idx,
  input  logic                                ld_valid,
  input  logic [$clog2(LQ_DEPTH)-1:0]         ld_lq_idx,
  output logic                                ld_shadowed,
  input  logic                                sq_valid,
  input  logic [$clog2(SB_DEPTH)-1:0]         sq_idx,
  output logic [REL_W-1:0]                    rel_valid,
  output logic [REL_W*$clog2(LQ_DEPTH)-1:0]   rel_lq_idx
);
  localparam int unsigned IW = $clog2(SB_DEPTH);
  localparam int unsigned PW = IW + 1;

  logic [PW-1:0] head_ptr, tail_ptr, head_nxt;
  logic          head_resolved, hold;
  logic [IW-1:0] sq_dist, ld_stamp;

  srt_caster_ring #(.DEPTH(SB_DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .cast_valid(cast_valid), .res_valid(res_valid), .res_idx(res_idx),
    .sq_valid(sq_valid), .sq_idx(sq_idx), .retire_ok(!hold),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .head_nxt(head_nxt),
    .head_resolved(head_resolved), .sq_dist(sq_dist)
  );

  always_comb begin
    ld_shadowed = ld_valid && !sq_valid && (cast_valid || (tail_ptr != head_nxt));
    ld_stamp    = cast_valid ? tail_ptr[IW-1:0] : tail_ptr[IW-1:0] - IW'(1);
  end

  srt_release_fifo #(.DEPTH(LQ_DEPTH), .SB_DEPTH(SB_DEPTH), .REL_W(REL_W)) u_relq (
    .clk(clk), .rst_n(rst_n),
    .push(ld_shadowed), .push_lq(ld_lq_idx), .push_stamp(ld_stamp),
    .sb_head(head_ptr[IW-1:0]), .head_resolved(head_resolved),
    .sq_valid(sq_valid), .sq_dist(sq_dist),
    .rel_valid(rel_valid), .rel_lq(rel_lq_idx), .hold(hold)
  );

  assign cast_idx = tail_ptr[IW-1:0];
endmodule

// File: rtl/srt_chk.sv
module srt_chk #(
  parameter int unsigned SB_DEPTH = 16,
  parameter int unsigned REL_W    = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cast_valid,
  input logic                        ld_valid,
  input logic                        ld_shadowed,
  input logic                        sq_valid,
  input logic [$clog2(SB_DEPTH)-1:0] sq_idx,
  input logic [REL_W-1:0]            rel_valid,
  input logic [$clog2(SB_DEPTH):0]   head_ptr,
  input logic [$clog2(SB_DEPTH):0]   tail_ptr,
  input logic                        head_resolved
);
  localparam int unsigned IW = $clog2(SB_DEPTH);
  localparam int unsigned PW = IW + 1;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cast_valid && !sq_valid |-> (tail_ptr - head_ptr) != PW'(SB_DEPTH)); // R2
  AST_CAST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    cast_valid && !sq_valid |=> tail_ptr == $past(tail_ptr) + PW'(1)); // R2
  AST_HOLD_UNRESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
    !head_resolved |=> $stable(head_ptr)); // R3
  AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    head_resolved |=> (head_ptr == $past(head_ptr)) || (head_ptr == $past(head_ptr) + PW'(1))); // R3
  AST_EMPTY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !cast_valid && !sq_valid && (head_ptr == tail_ptr) |-> !ld_shadowed); // R4
  AST_RELEASE_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_valid) |-> head_resolved); // R5
  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid & (rel_valid + REL_W'(1))) == '0); // R6
  AST_SQUASH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> tail_ptr[IW-1:0] == $past(sq_idx)); // R8
  AST_CAST_SHADOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && cast_valid && !sq_valid |-> ld_shadowed); // R9
endmodule

bind shadow_release_tracker srt_chk #(.SB_DEPTH(SB_DEPTH), .REL_W(REL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cast_valid(cast_valid), .ld_valid(ld_valid),
  .ld_shadowed(ld_shadowed), .sq_valid(sq_valid), .sq_idx(sq_idx),
  .rel_valid(rel_valid), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
  .head_resolved(head_resolved)
);

// File: tb/sim_shadow_release_tracker.sv
module sim_shadow_release_tracker;
  localparam int N  = 16;
  localparam int LQ = 8;
  localparam int W  = 2;
  localparam int IW = $clog2(N);
  localparam int LW = $clog2(LQ);

  logic clk = 1'b0;
  logic rst_n;
  logic cast_valid, res_valid, ld_valid, sq_valid, ld_shadowed;
  logic [IW-1:0] cast_idx, res_idx, sq_idx;
  logic [LW-1:0] ld_lq_idx;
  logic [W-1:0]  rel_valid;
  logic [W*LW-1:0] rel_lq_idx;

  shadow_release_tracker #(.SB_DEPTH(N), .LQ_DEPTH(LQ), .REL_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cast_valid(cast_valid), .cast_idx(cast_idx),
    .res_valid(res_valid), .res_idx(res_idx), .ld_valid(ld_valid),
    .ld_lq_idx(ld_lq_idx), .ld_shadowed(ld_shadowed), .sq_valid(sq_valid),
    .sq_idx(sq_idx), .rel_valid(rel_valid), .rel_lq_idx(rel_lq_idx)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  int m_head = 0, m_tail = 0;
  bit m_res [N];
  int p_lq[$], p_st[$];
  int lq_ctr = 0;
  bit after_sq = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  function automatic int lead_count(input int stamp);
    int c = 0;
    for (int i = 0; i < p_st.size(); i++) begin
      if (p_st[i] != stamp) break;
      c++;
    end
    return c;
  endfunction

  task automatic cyc(input bit cv, input bit rv, input int rseq, input bit lv,
                     input bit sv, input int sseq);
    int cnt, nrel, head_after, old_tail, lqid;
    bit hr, adv, exp_sh;
    string tg;
    lqid = lq_ctr % LQ;
    cast_valid = cv; res_valid = rv; res_idx = IW'(rseq % N);
    ld_valid = lv; ld_lq_idx = LW'(lqid); sq_valid = sv; sq_idx = IW'(sseq % N);
    #5;
    hr   = (m_head < m_tail) && m_res[m_head % N];
    cnt  = (hr && !sv) ? lead_count(m_head) : 0;
    nrel = (cnt < W) ? cnt : W;
    adv  = hr && !sv && (cnt <= W);
    head_after = m_head + (adv ? 1 : 0);
    exp_sh = lv && !sv && (cv || (m_tail != head_after));
    if (cnt > W) tg = "R7";
    else if (nrel > 0) tg = "R5";
    else if (rv && (m_head < m_tail) && (rseq == m_head) && !m_res[m_head % N]) tg = "R10";
    else tg = "R3";
    chk(tg, "rel_valid", int'(rel_valid), (1 << nrel) - 1);
    for (int k = 0; k < nrel; k++)
      chk("R6", "rel_lq_idx lane", int'(rel_lq_idx[k*LW +: LW]), p_lq[k]);
    if (cv && !sv) chk(after_sq ? "R8" : "R2", "cast_idx", int'(cast_idx), m_tail % N);
    if (lv) chk(!exp_sh ? "R4" : (cv ? "R9" : "R5"), "ld_shadowed", int'(ld_shadowed), int'(exp_sh));
    for (int k = 0; k < nrel; k++) begin
      void'(p_lq.pop_front());
      void'(p_st.pop_front());
    end
    m_head = head_after;
    old_tail = m_tail;
    if (sv) begin
      m_tail = sseq;
      while (p_st.size() > 0 && p_st[p_st.size()-1] >= sseq) begin
        void'(p_st.pop_back());
        void'(p_lq.pop_back());
      end
      after_sq = 1;
    end else begin
      if (cv) begin
        m_res[m_tail % N] = 1'b0;
        m_tail++;
        after_sq = 0;
      end
      if (exp_sh) begin
        p_lq.push_back(lqid);
        p_st.push_back(cv ? old_tail : old_tail - 1);
      end
      if (lv) lq_ctr++;
    end
    if (rv) m_res[rseq % N] = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got 0 exp 1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base, live, off, sseq;
    bit cv, lv, rv, sv;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) m_res[i] = 1'b0;
    rst_n = 1'b0;
    cast_valid = 0; res_valid = 0; ld_valid = 0; sq_valid = 0;
    res_idx = '0; sq_idx = '0; ld_lq_idx = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    ld_valid = 1'b1; #1;
    chk("R1", "rel_valid at reset", int'(rel_valid), 0);
    chk("R1", "cast_idx at reset", int'(cast_idx), 0);
    chk("R1", "ld_shadowed at reset", int'(ld_shadowed), 0);
    ld_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: empty ring, unshadowed load
    cyc(0, 0, 0, 1, 0, 0);
    // R9 then R7: three loads on one caster, resolved later
    base = m_tail;
    cyc(1, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 1, base, 0, 0, 0);
    idle(3);
    cyc(0, 0, 0, 1, 0, 0);
    // R3: out-of-order resolve
    base = m_tail;
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, 0, 0);
    cyc(0, 1, base + 1, 0, 0, 0);
    idle(2);
    cyc(0, 1, base, 0, 0, 0);
    idle(3);
    // R8: squash in the middle
    base = m_tail;
    cyc(1, 0, 0, 1, 0, 0);
    cyc(1, 0, 0, 1, 0, 0);
    cyc(1, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, base + 1);
    cyc(1, 0, 0, 1, 0, 0);
    cyc(0, 1, base, 0, 0, 0);
    cyc(0, 1, base + 1, 0, 0, 0);
    idle(4);

    // constrained random
    for (int it = 0; it < 4000; it++) begin
      live = m_tail - m_head;
      sv = (live > 0) && ($urandom % 40 == 0);
      sseq = sv ? m_head + int'($urandom % live) : 0;
      cv = !sv && (live < N) && ($urandom % 3 == 0);
      lv = !sv && (p_lq.size() < LQ - 1) && ($urandom % 3 == 0);
      rv = 0; off = 0;
      if (live > 0 && ($urandom % 2 == 0)) begin
        off = m_head + int'($urandom % live);
        rv = !m_res[off % N];
      end
      cyc(cv, rv, off, lv, sv, sseq);
    end
    // drain
    for (int i = 0; i < 3 * N; i++) begin
      rv = 0; off = 0;
      for (int s = m_head; s < m_tail; s++)
        if (!m_res[s % N]) begin rv = 1; off = s; break; end
      cyc(0, rv, off, 0, 0, 0);
    end
    chk("R5", "loads left pending", p_lq.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule